// File: doc/BRIEF.md
# Fractional Frequency Trim Accumulator

This block sets the rate of a nanosecond time counter that advances on a 125 MHz clock. On each clock the counter normally moves by 8 ns. A programmed fractional addend goes into a 30-bit accumulator on every clock. Each time the accumulator passes 2^30, the block's next increment output is 9 ns or 7 ns instead of 8 ns. A sign flag picks the direction. The increment output feeds the time counter directly.

Software programs the trim with five consecutive 16-bit writes to one drift address. These are a sign word, two padding words, the upper addend half and the lower addend half. The new sign and addend take effect together when the fifth word arrives. The accumulator keeps its contents across the update. The trim only acts while an enable bit in a separate control register is set. Addends above 2^29 are limited to 2^29, which caps the correction at half a nanosecond per cycle (6.25 %).

Top module: `drift_trim`

## Requirements
- R1: After reset the increment output is 8, the trim is disabled, the stored addend is zero and the write sequence expects its first word.
- R2: While the enable bit (bit 2 of the word written to the control address 0x04) is clear, the increment is 8 on every cycle.
- R3: While enabled with a zero addend, the increment is 8 on every cycle.
- R4: With the sign clear, each accumulator overflow makes the increment 9. Over any N cycles with a constant addend A, where N*A is a multiple of 2^30, exactly N*A/2^30 increments are 9 and none are 7.
- R5: With the sign set (bit 15 of the first sequence word), each overflow makes the increment 7 instead, at the same rate as R4.
- R6: On overflow the accumulator subtracts 2^30 and keeps the remainder, so an addend of 3*2^27 yields exactly 150 deviations in any 400 cycles.
- R7: A programmed addend above 2^29 acts as exactly 2^29, giving one deviation every two cycles.
- R8: The drift sequence on address 0x06 is: word 0 carries the sign in bit 15, words 1 and 2 are ignored, word 3 gives addend bits 31:16 and word 4 gives bits 15:0. Sign and addend change only when word 4 is written. A partial sequence leaves the active trim unchanged.
- R9: Writes to any address other than the drift address do not advance the drift sequence.
- R10: The increment is always 7, 8 or 9, and no two consecutive cycles both deviate from 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 125 MHz time-base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle per word |
| wr_addr | input | 8 | Write address |
| wr_data | input | 16 | Write data |
| incr_ns | output | 4 | Nanoseconds the time counter adds this cycle |

## Verification
A corrupted accumulator or a lost remainder does not show up on any single cycle. It shows up as the wrong number of 7 or 9 ns increments in a window of a few hundred cycles. The bench therefore counts deviations over windows whose length makes the expected count an exact integer, whatever phase the accumulator starts from. A misrouted sign or a sequence counter that commits early is visible within one window after the writes, as deviations in the wrong direction or at the wrong rate. Dropping the clamp produces back-to-back deviations within a few cycles of the commit.

// File: rtl/drift_pkg.sv
package drift_pkg;
    // position within the five-word drift write sequence
    typedef enum logic [2:0] {
        SLOT_SIGN = 3'd0,
        SLOT_PAD0 = 3'd1,
        SLOT_PAD1 = 3'd2,
        SLOT_HI   = 3'd3,
        SLOT_LO   = 3'd4
    } slot_e;
endpackage

// File: rtl/drift_cfg_regs.sv
module drift_cfg_regs
    import drift_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int DRIFT_ADDR = 6,
    parameter int CTRL_ADDR  = 4,
    parameter int EN_BIT     = 2,
    parameter int SIGN_BIT   = 15,
    parameter int FRAC_W     = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [FRAC_W-1:0] addend,
    output logic              neg,
    output logic              en
);
    localparam int SEQ_W = 2 * DATA_W;
    localparam logic [SEQ_W-1:0] CLAMP_VAL = SEQ_W'(1) << (FRAC_W - 1);
    localparam logic [ADDR_W-1:0] DRIFT_A = ADDR_W'(DRIFT_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_ADDR);

    typedef struct packed {
        slot_e             slot;
        logic              neg_pend;
        logic [DATA_W-1:0] hi_pend;
        logic [FRAC_W-1:0] addend;
        logic              neg;
        logic              en;
    } cfg_t;

    cfg_t q, d;
    logic hit_drift, hit_ctrl;
    logic [SEQ_W-1:0] full_w;

    assign hit_drift = wr_en && (wr_addr == DRIFT_A);
    assign hit_ctrl  = wr_en && (wr_addr == CTRL_A);
    assign full_w    = {q.hi_pend, wr_data};

    always_comb begin
        d = q;
        if (hit_ctrl) begin
            d.en = wr_data[EN_BIT];
        end
        if (hit_drift) begin
            case (q.slot)
                SLOT_SIGN: begin
                    d.neg_pend = wr_data[SIGN_BIT];
                    d.slot     = SLOT_PAD0;
                end
                SLOT_PAD0: d.slot = SLOT_PAD1;
                SLOT_PAD1: d.slot = SLOT_HI;
                SLOT_HI: begin
                    d.hi_pend = wr_data;
                    d.slot    = SLOT_LO;
                end
                SLOT_LO: begin
                    // sign and addend switch together; values past the cap are limited
                    if (full_w > CLAMP_VAL) begin
                        d.addend = CLAMP_VAL[FRAC_W-1:0];
                    end else begin
                        d.addend = full_w[FRAC_W-1:0];
                    end
                    d.neg  = q.neg_pend;
                    d.slot = SLOT_SIGN;
                end
                default: d.slot = SLOT_SIGN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{slot: SLOT_SIGN, neg_pend: 1'b0, hi_pend: '0,
                   addend: '0, neg: 1'b0, en: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign addend = q.addend;
    assign neg    = q.neg;
    assign en     = q.en;

    assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        q.addend <= CLAMP_VAL[FRAC_W-1:0]);

    assert_commit_on_fifth_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_drift && q.slot == SLOT_LO) |=> ($stable(q.addend) && $stable(q.neg)));

    assert_foreign_no_advance_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_drift |=> $stable(q.slot));
endmodule

// File: rtl/drift_accum.sv
module drift_accum #(
    parameter int FRAC_W = 30,
    parameter int INC_W  = 4,
    parameter int NOM_NS = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FRAC_W-1:0] addend,
    input  logic              neg,
    input  logic              en,
    output logic [INC_W-1:0]  incr
);
    localparam logic [INC_W-1:0] NOM    = INC_W'(NOM_NS);
    localparam logic [INC_W-1:0] NOM_HI = INC_W'(NOM_NS + 1);
    localparam logic [INC_W-1:0] NOM_LO = INC_W'(NOM_NS - 1);

    typedef struct packed {
        logic [FRAC_W-1:0] acc;
        logic [INC_W-1:0]  incr;
    } acc_t;

    acc_t q, d;
    logic [FRAC_W:0] sum;
    logic            carry;

    assign sum   = {1'b0, q.acc} + {1'b0, addend};
    assign carry = sum[FRAC_W];

    always_comb begin
        d = q;
        if (en) begin
            // dropping the top bit subtracts 2^FRAC_W and keeps the remainder
            d.acc = sum[FRAC_W-1:0];
            if (carry) begin
                d.incr = neg ? NOM_LO : NOM_HI;
            end else begin
                d.incr = NOM;
            end
        end else begin
            d.incr = NOM;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{acc: '0, incr: NOM};
        end else begin
            q <= d;
        end
    end

    assign incr = q.incr;

    assert_incr_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.incr == NOM) || (q.incr == NOM_HI) || (q.incr == NOM_LO));

    assert_no_back_to_back_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.incr != NOM) |=> (q.incr == NOM));
endmodule

// File: rtl/drift_trim.sv
module drift_trim #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int DRIFT_ADDR = 6,
    parameter int CTRL_ADDR  = 4,
    parameter int EN_BIT     = 2,
    parameter int SIGN_BIT   = 15,
    parameter int FRAC_W     = 30,
    parameter int INC_W      = 4,
    parameter int NOM_NS     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [INC_W-1:0]  incr_ns
);
    localparam logic [INC_W-1:0] NOM    = INC_W'(NOM_NS);
    localparam logic [INC_W-1:0] NOM_HI = INC_W'(NOM_NS + 1);
    localparam logic [INC_W-1:0] NOM_LO = INC_W'(NOM_NS - 1);

    logic [FRAC_W-1:0] addend_w;
    logic              neg_w;
    logic              en_w;

    drift_cfg_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DRIFT_ADDR(DRIFT_ADDR),
        .CTRL_ADDR(CTRL_ADDR), .EN_BIT(EN_BIT), .SIGN_BIT(SIGN_BIT),
        .FRAC_W(FRAC_W)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .addend(addend_w), .neg(neg_w), .en(en_w)
    );

    drift_accum #(
        .FRAC_W(FRAC_W), .INC_W(INC_W), .NOM_NS(NOM_NS)
    ) accum_i (
        .clk(clk), .rst_n(rst_n), .addend(addend_w), .neg(neg_w),
        .en(en_w), .incr(incr_ns)
    );

    assert_disabled_nominal_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_w |=> (incr_ns == NOM));

    assert_zero_addend_nominal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en_w && addend_w == '0) |=> (incr_ns == NOM));

    assert_sign_direction_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (incr_ns != NOM) |-> (incr_ns == ($past(neg_w) ? NOM_LO : NOM_HI)));
endmodule

// File: tb/drift_trim_tb_top.sv
module drift_trim_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  incr_ns;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int n_hi, n_lo, n_bad, n_b2b;

    always #2.5 clk = ~clk;

    drift_trim dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .incr_ns(incr_ns)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load(input bit neg, input logic [31:0] val);
        wr(8'h06, neg ? 16'h8000 : 16'h0000);
        wr(8'h06, 16'h0000);
        wr(8'h06, 16'h0000);
        wr(8'h06, val[31:16]);
        wr(8'h06, val[15:0]);
    endtask

    task automatic set_en(input bit on);
        wr(8'h04, on ? 16'h0004 : 16'h0000);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic measure(input int n);
        bit prev = 0;
        n_hi = 0; n_lo = 0; n_bad = 0; n_b2b = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (incr_ns == 4'd9) n_hi++;
            else if (incr_ns == 4'd7) n_lo++;
            else if (incr_ns != 4'd8) n_bad++;
            if (incr_ns != 4'd8 && prev) n_b2b++;
            prev = (incr_ns != 4'd8);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(incr_ns == 4'd8, "R1 reset increment", incr_ns, 8);
        set_en(1'b1);
        settle();
        measure(200);
        chk(n_hi + n_lo == 0, "R1 reset addend zero", n_hi + n_lo, 0);
    endtask

    task automatic t_positive();
        load(1'b0, 32'h1000_0000);
        settle();
        measure(400);
        chk(n_hi == 100, "R4 overflow count", n_hi, 100);
        chk(n_lo == 0, "R4 no negative steps", n_lo, 0);
    endtask

    task automatic t_negative();
        load(1'b1, 32'h1000_0000);
        settle();
        measure(400);
        chk(n_lo == 100, "R5 negative steps", n_lo, 100);
        chk(n_hi == 0, "R5 no positive steps", n_hi, 0);
    endtask

    task automatic t_remainder();
        load(1'b0, 32'h1800_0000);
        settle();
        measure(400);
        chk(n_hi == 150, "R6 remainder kept", n_hi, 150);
    endtask

    task automatic t_clamp();
        load(1'b0, 32'hFFFF_FFFF);
        settle();
        measure(400);
        chk(n_hi == 200, "R7 clamp max", n_hi, 200);
        chk(n_b2b == 0, "R10 no consecutive deviations", n_b2b, 0);
        chk(n_bad == 0, "R10 range", n_bad, 0);
        load(1'b0, 32'h2000_0001);
        settle();
        measure(400);
        chk(n_hi == 200, "R7 clamp just above cap", n_hi, 200);
    endtask

    task automatic t_sequence();
        // active: positive 2^29 from t_clamp; start a negative sequence halfway
        wr(8'h06, 16'h8000);
        wr(8'h06, 16'h0000);
        wr(8'h06, 16'h0000);
        settle();
        measure(400);
        chk(n_hi == 200 && n_lo == 0, "R8 partial sequence keeps trim", n_hi, 200);
        wr(8'h06, 16'h1000);
        wr(8'h06, 16'h0000);
        settle();
        measure(400);
        chk(n_lo == 100 && n_hi == 0, "R8 commit on fifth word", n_lo, 100);
    endtask

    task automatic t_foreign();
        wr(8'h06, 16'h0000);
        wr(8'h10, 16'hFFFF);
        wr(8'h10, 16'hFFFF);
        wr(8'h10, 16'hFFFF);
        wr(8'h06, 16'h0000);
        wr(8'h06, 16'h0000);
        wr(8'h06, 16'h1000);
        wr(8'h06, 16'h0000);
        settle();
        measure(400);
        chk(n_hi == 100 && n_lo == 0, "R9 foreign writes ignored", n_hi, 100);
    endtask

    task automatic t_disable();
        load(1'b0, 32'h2000_0000);
        set_en(1'b0);
        settle();
        measure(400);
        chk(n_hi + n_lo + n_bad == 0, "R2 disabled nominal", n_hi + n_lo + n_bad, 0);
        set_en(1'b1);
        settle();
        measure(400);
        chk(n_hi == 200, "R2 re-enabled trims", n_hi, 200);
    endtask

    task automatic t_zero();
        load(1'b1, 32'h0000_0000);
        settle();
        measure(400);
        chk(n_hi + n_lo + n_bad == 0, "R3 zero addend nominal", n_hi + n_lo + n_bad, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_positive();
        t_negative();
        t_remainder();
        t_clamp();
        t_sequence();
        t_foreign();
        t_disable();
        t_zero();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule